// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an on-chip port that carries one transfer at a time to an asynchronous external memory bus. The port uses a valid/ready handshake and carries an address, write data, byte enables and a read/write flag. Address and data share one 16-bit bus. The block presents the address while an address-latch strobe is high, then moves the same lines to the data phase. That phase uses active-low read or write strobes, one active-low chip select for each region, and two active-low byte-lane strobes.

The two upper request address bits pick one of four regions. Each region has its own enable, its own data width (8 or 16 bits) and its own 16-bit timing word. The timing word sets:
- how long the latch strobe lasts,
- whether the address is held for an extra clock,
- whether idle clocks surround each strobe,
- the length of the read strobe and of the write strobe,
- whether the byte-lane strobes act as per-byte write strobes.

All of these are written through a small register write port. A global enable bit must be set before any request is accepted.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the global enable is 0, every region is disabled in 8-bit mode with timing word 0x70FF, and the outputs are idle: `bus_ale`=0, `bus_rd_n`=`bus_wr_n`=1, all `bus_cs_n`=1, `bus_bs_n`=2'b11, `bus_ad_oe`=0, `bus_ad_o`=0, `req_ready`=0, `resp_valid`=0.
- R2: Configuration writes are addressed by `cfg_sel`: 0 writes the global enable (data bit 0), 1 writes the region control of `cfg_idx` (bit 0 enable, bit 1 width: 1=16-bit), 2 writes its timing word. While the global enable is 0, `req_ready` stays low and the bus stays idle.
- R3: The region is `req_addr[17:16]`. A request to a disabled region produces `resp_valid` with `resp_err`=1 in the cycle after acceptance, with no chip select or strobe. In all other cases at most one `bus_cs_n` bit is low, and it stays low from the first latch cycle to the last cycle of the final access.
- R4: Each access begins with `bus_ale` high for (timing bits 14:12)+1 clocks, with `bus_ad_o` carrying the access address and `bus_ad_oe`=1.
- R5: When timing bit 10 is 0, one further clock follows the latch phase with `bus_ale` low and the address still driven. When bit 10 is 1, no such clock is added.
- R6: A read drives `bus_rd_n` low for (bits 3:0)+1 clocks with `bus_ad_oe`=0. When bit 9 is 0, one idle clock with `bus_ad_oe`=0 comes right before the strobe and another right after it. Read data is taken from `bus_ad_i` in the last strobe clock.
- R7: A write drives `bus_wr_n` low for (bits 7:4)+1 clocks. When bit 8 is 0, one idle clock comes before the strobe and one after it. Write data is driven with `bus_ad_oe`=1 from the end of the address phase through the last write clock.
- R8: A 16-bit region makes one access at the request address, with the full 16-bit word on the bus and `bus_bs_n`=~`req_be` (bit 1 is the high byte) throughout the access.
- R9: An 8-bit region makes one complete access for each set byte enable, low byte first. Byte k uses address offset+k and is carried on `bus_ad_o[7:0]` / `bus_ad_i[7:0]`. Read bytes are merged into `resp_rdata` at byte position k. Bytes that were not requested read as 0.
- R10: When timing bit 15 is 1, `bus_bs_n` is 2'b11 except during the write strobe. During the strobe the selected lane goes low. In 8-bit mode the lane is address bit 0 of the access (1 selects bit 1). In 16-bit mode the lanes are the byte enables. When bit 15 is 0, in 8-bit mode `bus_bs_n` marks that same lane for the whole access.
- R11: `resp_valid` is high for exactly one clock, in the cycle after the last bus clock. `resp_rdata` is 0 outside that cycle. `req_ready` is high in every idle cycle with the global enable set, starting with the cycle after the response.
- R12: A request runs to completion with the region settings captured when it was accepted. Configuration writes made during the transfer affect only later requests.
- R13: A request with `req_be`=0 to an enabled region responds in the next cycle with `resp_err`=0, `resp_rdata`=0 and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 global enable, 1 region control, 2 region timing |
| cfg_idx | input | 2 | Region addressed by a configuration write |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 18 | Region in bits 17:16, offset in bits 15:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 high byte |
| resp_valid | output | 1 | Completion pulse |
| resp_err | output | 1 | Disabled region addressed |
| resp_rdata | output | 16 | Read data |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 4 | Region chip selects, active low |
| bus_bs_n | output | 2 | Byte-lane strobes, active low |
| bus_ad_o | output | 16 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | 16 | Multiplexed data in |

## Verification
The assertions assume the following about the inputs:
- `req_addr`, `req_write`, `req_wdata` and `req_be` stay steady while `req_valid` waits for `req_ready`.
- `cfg_idx` names an existing region.

Under those assumptions they check that at most one chip select is active, that the two strobes never overlap, and that the shared lines are released whenever the read strobe is low.

The stimulus respects these assumptions by design:
- It changes request fields only after it sees acceptance.
- It uses only the three defined `cfg_sel` codes.
- It drives `bus_ad_i` with a value that changes every cycle, so a sample taken one cycle early or late shows up in `resp_rdata`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int LANE_W = 16;
  localparam logic [15:0] TIMING_RST = 16'h70FF;
  localparam logic [15:0] TIMING_RSVD = 16'h0800;

  localparam logic [1:0] SEL_GLB = 2'd0;
  localparam logic [1:0] SEL_CTL = 2'd1;
  localparam logic [1:0] SEL_TIM = 2'd2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ALE, PH_HOLD, PH_PRE, PH_STRB, PH_POST, PH_RESP
  } phase_t;

  typedef struct packed {
    logic       byte_gate;  // 15
    logic [2:0] ale_ws;     // 14:12
    logic       rsvd;       // 11
    logic       no_hold;    // 10
    logic       no_rturn;   // 9
    logic       no_wturn;   // 8
    logic [3:0] wr_len;     // 7:4
    logic [3:0] rd_len;     // 3:0
  } timing_t;

  typedef struct packed {
    logic wide;  // 1
    logic en;    // 0
  } rctl_t;
endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg import xbus_pkg::*; #(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [RW-1:0]         cfg_idx,
  input  logic [LANE_W-1:0]     cfg_wdata,
  output logic                  glb_en,
  output rctl_t   [NREG-1:0]    rctl,
  output timing_t [NREG-1:0]    rtim
);
  always_ff @(posedge clk) begin
    if (rst) glb_en <= 1'b0;
    else if (cfg_we && cfg_sel == SEL_GLB) glb_en <= cfg_wdata[0];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_region
    rctl_t   ctl_q;
    timing_t tim_q;
    logic    hit;
    assign hit = cfg_we && (cfg_idx == RW'(r));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q <= '0;
        tim_q <= timing_t'(TIMING_RST);
      end else if (hit) begin
        if (cfg_sel == SEL_CTL) ctl_q <= rctl_t'(cfg_wdata[1:0]);
        if (cfg_sel == SEL_TIM) tim_q <= timing_t'(cfg_wdata & ~TIMING_RSVD);
      end
    end

    assign rctl[r] = ctl_q;
    assign rtim[r] = tim_q;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq import xbus_pkg::*; #(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG),
  localparam int AW = RW + LANE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  glb_en,
  input  rctl_t   [NREG-1:0]    rctl,
  input  timing_t [NREG-1:0]    rtim,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [LANE_W-1:0]     req_wdata,
  input  logic [1:0]            req_be,
  output logic                  resp_valid,
  output logic                  resp_err,
  output logic [LANE_W-1:0]     resp_rdata,
  output logic                  bus_ale,
  output logic                  bus_rd_n,
  output logic                  bus_wr_n,
  output logic [NREG-1:0]       bus_cs_n,
  output logic [1:0]            bus_bs_n,
  output logic [LANE_W-1:0]     bus_ad_o,
  output logic                  bus_ad_oe,
  input  logic [LANE_W-1:0]     bus_ad_i
);
  phase_t             ph_q, ph_d;
  logic [3:0]         cnt_q, cnt_d;
  logic [1:0]         pend_q, pend_d;
  logic [RW-1:0]      rg_q;
  logic               wr_q, wide_q, err_q;
  timing_t            tim_q;
  logic [LANE_W-1:0]  off_q, wdat_q, rdat_q;
  logic [1:0]         be_q;

  // request side decode
  logic               accept;
  logic [RW-1:0]      req_rg;
  rctl_t              sel_ctl;
  timing_t            sel_tim;
  assign req_ready = (ph_q == PH_IDLE) && glb_en;
  assign accept    = req_valid && req_ready;
  assign req_rg    = req_addr[AW-1 -: RW];
  assign sel_ctl   = rctl[req_rg];
  assign sel_tim   = rtim[req_rg];

  // current access
  logic               cur_k, turn, last, in_beat, addr_ph;
  logic [LANE_W-1:0]  beat_addr, data_out;
  logic [1:0]         lane, pend_after;
  logic [3:0]         strb_len;
  phase_t             beat_next;
  assign cur_k      = ~pend_q[0];
  assign beat_addr  = wide_q ? off_q : off_q + LANE_W'(cur_k);
  assign lane       = wide_q ? be_q : (beat_addr[0] ? 2'b10 : 2'b01);
  assign turn       = wr_q ? ~tim_q.no_wturn : ~tim_q.no_rturn;
  assign strb_len   = wr_q ? tim_q.wr_len : tim_q.rd_len;
  assign last       = (cnt_q == 4'd0);
  assign pend_after = wide_q ? 2'b00 : (pend_q & ~(cur_k ? 2'b10 : 2'b01));
  assign beat_next  = (pend_after != 2'b00) ? PH_ALE : PH_RESP;
  assign data_out   = wide_q ? wdat_q
                             : {8'h00, (cur_k ? wdat_q[15:8] : wdat_q[7:0])};

  always_comb begin
    ph_d   = ph_q;
    pend_d = pend_q;
    unique case (ph_q)
      PH_IDLE: if (accept) begin
        pend_d = req_be;
        ph_d   = (!sel_ctl.en || req_be == 2'b00) ? PH_RESP : PH_ALE;
      end
      PH_ALE:  if (last) ph_d = !tim_q.no_hold ? PH_HOLD : (turn ? PH_PRE : PH_STRB);
      PH_HOLD: ph_d = turn ? PH_PRE : PH_STRB;
      PH_PRE:  ph_d = PH_STRB;
      PH_STRB: if (last) begin
        ph_d = turn ? PH_POST : beat_next;
        if (!turn) pend_d = pend_after;
      end
      PH_POST: begin
        ph_d   = beat_next;
        pend_d = pend_after;
      end
      PH_RESP: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase

    cnt_d = cnt_q - 4'd1;
    if (ph_d != ph_q) begin
      if (ph_d == PH_ALE)
        cnt_d = {1'b0, (ph_q == PH_IDLE) ? sel_tim.ale_ws : tim_q.ale_ws};
      else if (ph_d == PH_STRB)
        cnt_d = strb_len;
      else
        cnt_d = 4'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      pend_q <= '0;
      rg_q   <= '0;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      err_q  <= 1'b0;
      tim_q  <= '0;
      off_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      be_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      if (accept) begin
        rg_q   <= req_rg;
        wr_q   <= req_write;
        wide_q <= sel_ctl.wide;
        err_q  <= !sel_ctl.en;
        tim_q  <= sel_tim;
        off_q  <= req_addr[LANE_W-1:0];
        wdat_q <= req_wdata;
        be_q   <= req_be;
        rdat_q <= '0;
      end else if (ph_q == PH_STRB && last && !wr_q) begin
        if (wide_q)     rdat_q <= bus_ad_i & {{8{be_q[1]}}, {8{be_q[0]}}};
        else if (cur_k) rdat_q[15:8] <= bus_ad_i[7:0];
        else            rdat_q[7:0]  <= bus_ad_i[7:0];
      end
    end
  end

  // bus outputs decoded from state flops only
  assign in_beat   = ph_q inside {PH_ALE, PH_HOLD, PH_PRE, PH_STRB, PH_POST};
  assign addr_ph   = ph_q inside {PH_ALE, PH_HOLD};
  assign bus_ale   = (ph_q == PH_ALE);
  assign bus_rd_n  = !(ph_q == PH_STRB && !wr_q);
  assign bus_wr_n  = !(ph_q == PH_STRB && wr_q);
  assign bus_ad_oe = addr_ph || (wr_q && (ph_q inside {PH_PRE, PH_STRB, PH_POST}));
  assign bus_ad_o  = addr_ph ? beat_addr : (bus_ad_oe ? data_out : '0);
  assign bus_bs_n  = tim_q.byte_gate ? ~(lane & {2{~bus_wr_n}})
                                     : (in_beat ? ~lane : 2'b11);

  for (genvar r = 0; r < NREG; r++) begin : g_cs
    assign bus_cs_n[r] = !(in_beat && rg_q == RW'(r));
  end

  assign resp_valid = (ph_q == PH_RESP);
  assign resp_err   = resp_valid && err_q;
  assign resp_rdata = resp_valid ? rdat_q : '0;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n)); // R3
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> $past(&bus_cs_n)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    bus_rd_n || bus_wr_n); // R6
  AST_READ_HIZ: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_ad_oe); // R6
  AST_ALE_CS: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> !(&bus_cs_n)); // R4
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R11
  AST_GATED_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !glb_en |-> !req_ready); // R2
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl import xbus_pkg::*; #(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG),
  localparam int AW = RW + LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [RW-1:0]     cfg_idx,
  input  logic [LANE_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [LANE_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [LANE_W-1:0] resp_rdata,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [NREG-1:0]   bus_cs_n,
  output logic [1:0]        bus_bs_n,
  output logic [LANE_W-1:0] bus_ad_o,
  output logic              bus_ad_oe,
  input  logic [LANE_W-1:0] bus_ad_i
);
  logic                 glb_en;
  rctl_t   [NREG-1:0]   rctl;
  timing_t [NREG-1:0]   rtim;

  xbus_cfg #(.NREG(NREG)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .glb_en(glb_en), .rctl(rctl), .rtim(rtim)
  );

  xbus_seq #(.NREG(NREG)) u_seq (
    .clk(clk), .rst(rst), .glb_en(glb_en), .rctl(rctl), .rtim(rtim),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_cs_n(bus_cs_n), .bus_bs_n(bus_bs_n), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i)
  );
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0, cfg_idx = 0; logic [15:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0; logic [17:0] req_addr = 0;
  logic [15:0] req_wdata = 0; logic [1:0] req_be = 0;
  logic req_ready, resp_valid, resp_err; logic [15:0] resp_rdata;
  logic bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe; logic [3:0] bus_cs_n;
  logic [1:0] bus_bs_n; logic [15:0] bus_ad_o; logic [15:0] bus_ad_i = 0;

  xbus_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic ale, rd_n, wr_n; logic [3:0] cs_n; logic [1:0] bs_n; logic oe;
    logic [15:0] ad; logic rv, err; logic [15:0] rdata;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit acc_flag = 0;
  bit m_gen = 0; bit m_en[4]; bit m_wide[4]; logic [15:0] m_tim[4];

  function automatic logic [15:0] ad_pat(input int n);
    return 16'(n * 40503) ^ 16'h3C5A;
  endfunction

  function automatic exp_t idle_rec();
    exp_t e;
    e = '0; e.rd_n = 1; e.wr_n = 1; e.cs_n = 4'hF; e.bs_n = 2'b11;
    return e;
  endfunction

  task automatic ck(input bit ok, input string tag, input string what,
                    input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  // Reference model: lay out every expected bus cycle at acceptance time.
  function automatic void plan_req(input logic [17:0] a, input logic w,
                                   input logic [15:0] wd, input logic [1:0] be);
    int rg; logic [15:0] t, addr, data, rd, smp; logic [1:0] lane, nbs; bit wide, turn;
    int base, len, idx; exp_t e;
    rg = int'(a[17:16]); t = m_tim[rg] & 16'hF7FF; wide = m_wide[rg];
    base = cyc + 1; rd = 16'h0000;
    if (!m_en[rg] || be == 2'b00) begin
      e = idle_rec(); e.rv = 1; e.err = !m_en[rg]; q.push_back(e); return;
    end
    for (int k = 0; k < 2; k++) begin
      if (wide && k == 1) break;
      if (!wide && !be[k]) continue;
      addr = wide ? a[15:0] : a[15:0] + 16'(k);
      lane = wide ? be : (addr[0] ? 2'b10 : 2'b01);
      data = wide ? wd : {8'h00, (k == 1 ? wd[15:8] : wd[7:0])};
      turn = w ? !t[8] : !t[9];
      nbs  = t[15] ? 2'b11 : ~lane;
      e = idle_rec(); e.cs_n[rg] = 0; e.bs_n = nbs; e.oe = 1; e.ad = addr;
      e.ale = 1;
      for (int i = 0; i <= int'(t[14:12]); i++) q.push_back(e);       // R4
      e.ale = 0;
      if (!t[10]) q.push_back(e);                                     // R5
      e.oe = w; e.ad = w ? data : 16'h0;
      if (turn) q.push_back(e);                                       // R6 R7
      len = w ? int'(t[7:4]) : int'(t[3:0]);
      if (w) begin e.wr_n = 0; if (t[15]) e.bs_n = ~lane; end           // R10
      else e.rd_n = 0;
      for (int i = 0; i <= len; i++) q.push_back(e);
      idx = base + q.size() - 1;
      smp = ad_pat(idx);
      if (!w) begin
        if (wide) rd = smp & {{8{be[1]}}, {8{be[0]}}};
        else if (k == 1) rd[15:8] = smp[7:0];                         // R9
        else rd[7:0] = smp[7:0];
      end
      e.rd_n = 1; e.wr_n = 1; e.bs_n = nbs;
      if (turn) q.push_back(e);
    end
    e = idle_rec(); e.rv = 1; e.rdata = rd; q.push_back(e);           // R11
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    exp_t e; bit busy;
    bus_ad_i = ad_pat(cyc);
    if (!rst) begin
      busy = q.size() != 0;
      e = busy ? q.pop_front() : idle_rec();
      ck(bus_ale == e.ale, "R4", "ale", 32'(bus_ale), 32'(e.ale));
      ck(bus_cs_n == e.cs_n, "R3", "cs_n", 32'(bus_cs_n), 32'(e.cs_n));
      ck(bus_rd_n == e.rd_n, "R6", "rd_n", 32'(bus_rd_n), 32'(e.rd_n));
      ck(bus_wr_n == e.wr_n, "R7", "wr_n", 32'(bus_wr_n), 32'(e.wr_n));
      ck(bus_ad_oe == e.oe, "R6", "ad_oe", 32'(bus_ad_oe), 32'(e.oe));
      ck(bus_ad_o == e.ad, "R5", "ad_o", 32'(bus_ad_o), 32'(e.ad));
      ck(bus_bs_n == e.bs_n, "R10", "bs_n", 32'(bus_bs_n), 32'(e.bs_n));
      ck(resp_valid == e.rv, "R11", "resp_valid", 32'(resp_valid), 32'(e.rv));
      ck(resp_err == e.err, "R3", "resp_err", 32'(resp_err), 32'(e.err));
      ck(resp_rdata == e.rdata, "R9", "resp_rdata", 32'(resp_rdata), 32'(e.rdata));
      ck(req_ready == (!busy && m_gen), "R2", "req_ready", 32'(req_ready),
         32'(!busy && m_gen));
      if (req_valid && !busy && m_gen) begin
        plan_req(req_addr, req_write, req_wdata, req_be);
        acc_flag = 1;
      end
      if (cfg_we) begin
        if (cfg_sel == 2'd0) m_gen = cfg_wdata[0];
        if (cfg_sel == 2'd1) begin m_en[cfg_idx] = cfg_wdata[0]; m_wide[cfg_idx] = cfg_wdata[1]; end
        if (cfg_sel == 2'd2) m_tim[cfg_idx] = cfg_wdata;
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] s, input logic [1:0] i, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = s; cfg_idx = i; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send(input logic [17:0] a, input logic w,
                      input logic [15:0] wd, input logic [1:0] be);
    @(posedge clk); #1;
    acc_flag = 0;
    req_valid = 1; req_addr = a; req_write = w; req_wdata = wd; req_be = be;
    do @(posedge clk); while (!acc_flag);
    #1 req_valid = 0;
  endtask

  task automatic drain();
    do @(posedge clk); while (q.size() != 0);
  endtask

  task automatic xfer(input logic [17:0] a, input logic w,
                      input logic [15:0] wd, input logic [1:0] be);
    send(a, w, wd, be);
    drain();
  endtask

  initial begin
    for (int r = 0; r < 4; r++) begin m_en[r] = 0; m_wide[r] = 0; m_tim[r] = 16'h70FF; end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #2;
    // R1: idle outputs after reset
    ck(bus_ale == 0 && bus_rd_n && bus_wr_n, "R1", "strobes", {bus_ale, bus_rd_n, bus_wr_n}, 3'b011);
    ck(bus_cs_n == 4'hF && bus_bs_n == 2'b11, "R1", "selects", {bus_cs_n, bus_bs_n}, 6'h3F);
    ck(!bus_ad_oe && bus_ad_o == 0, "R1", "ad", {bus_ad_oe, bus_ad_o}, 0);
    ck(!req_ready && !resp_valid, "R1", "handshake", {req_ready, resp_valid}, 0);

    // R2: valid held with global enable clear is never taken
    @(posedge clk); #1;
    req_valid = 1; req_addr = 18'h00010; req_write = 0; req_be = 2'b11;
    repeat (6) @(posedge clk);
    #1 req_valid = 0;
    cfg_wr(2'd0, 2'd0, 16'h0001);

    // R3: region 1 still disabled -> error response
    xfer(18'h1_1234, 0, 16'h0, 2'b11);
    // R1: default timing word 0x70FF on an enabled 8-bit region; R9 two-byte read
    cfg_wr(2'd1, 2'd0, 16'h0001);
    xfer(18'h0_0040, 0, 16'h0, 2'b11);
    // R13: no byte enables
    xfer(18'h0_0040, 1, 16'hFFFF, 2'b00);

    // R5 R6 R7 R8: 16-bit region with hold and turnaround
    cfg_wr(2'd1, 2'd1, 16'h0003);
    cfg_wr(2'd2, 2'd1, 16'h1832);   // bit 11 set is stored as 0
    xfer(18'h1_A5A4, 1, 16'hBEEF, 2'b11);
    xfer(18'h1_0102, 0, 16'h0, 2'b10);
    xfer(18'h1_0102, 0, 16'h0, 2'b11);

    // R10 R9: 8-bit region with gated byte writes, odd start address
    cfg_wr(2'd1, 2'd2, 16'h0001);
    cfg_wr(2'd2, 2'd2, 16'h8700);
    xfer(18'h2_0011, 1, 16'hC3D4, 2'b11);
    xfer(18'h2_0020, 0, 16'h0, 2'b10);
    // R10: gated mode on a 16-bit region, low lane only
    cfg_wr(2'd1, 2'd3, 16'h0003);
    cfg_wr(2'd2, 2'd3, 16'hA401);
    xfer(18'h3_0800, 1, 16'h1357, 2'b01);
    xfer(18'h3_0800, 0, 16'h0, 2'b11);
    // R8: normal lanes on a 16-bit region, high byte write
    cfg_wr(2'd2, 2'd3, 16'h0311);
    xfer(18'h3_0900, 1, 16'h2468, 2'b10);

    // R12: timing rewritten while a transfer runs
    send(18'h0_0100, 1, 16'h5566, 2'b11);
    cfg_wr(2'd2, 2'd0, 16'h0000);
    drain();
    xfer(18'h0_0100, 0, 16'h0, 2'b01);

    // R11: back-to-back requests, ready the cycle after a response
    send(18'h2_0030, 0, 16'h0, 2'b01);
    drain();
    #1 req_valid = 1; req_addr = 18'h2_0031; req_write = 1; req_wdata = 16'h00AA; req_be = 2'b01;
    acc_flag = 0;
    do @(posedge clk); while (!acc_flag);
    #1 req_valid = 0;
    drain();

    // R2: global disable blocks new requests again
    cfg_wr(2'd0, 2'd0, 16'h0000);
    @(posedge clk); #1;
    req_valid = 1; req_addr = 18'h1_0000; req_be = 2'b11;
    repeat (4) @(posedge clk);
    #1 req_valid = 0;
    repeat (3) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule